// File: doc/BRIEF.md
# UART Transmit Holding and Shift Sequencer

This block decides when each byte written by the host leaves the transmit holding stage and enters the transmit shift register, and when the shifted frame is finished. The holding stage is either a single holding register or a 16-entry queue, chosen by a mode input. A free-running bit-period tick is derived from a 16-bit divisor. Every sequencing decision is made on that tick. The block computes the frame length from the word-length, stop-bit and parity fields of the line control input.

The block reports the two line-status flags. The holding-empty flag is set when nothing waits in the holding stage. The transmitter-empty flag is set only when the holding stage and the shift register are both empty. It also raises a maskable transmit-empty interrupt request. A host bus decoder and a bit serializer sit around it. The decoder drives writes, the line-control value, the mode, the divisor and the interrupt enable and acknowledge. The serializer uses the load and completion pulses.

Top module: `uart_tx_sequencer`

## Requirements
- R1: After reset, lsr_thre and lsr_temt are 1, and tx_irq, tx_load and byte_done are 0.
- R2: bit_tick pulses for one clock every divisor × 16 clocks. A divisor of 0 counts as 65536, so no tick comes within thousands of clocks.
- R3: When the sequencer is idle, a written byte moves into the shift register on the first bit tick after the write. tx_load pulses in the clock after that tick.
- R4: Counting ticks from 0 at the idle write, byte_done pulses after tick number F+1, with done_data equal to the byte. F = 1 + (lcr[1:0]+5) + 1 + lcr[2] + lcr[3], where lcr[1:0] selects 5 to 8 data bits, lcr[2] adds a second stop bit and lcr[3] adds a parity bit.
- R5: If a byte waits in the holding stage when a frame completes, the tick counter restarts at 0. The waiting byte loads when the counter reaches D+1, where D is the data-bit count, and it completes when the counter reaches F+1. Consecutive completions are therefore F+1 ticks apart.
- R6: With fifo_en = 0, a write always lands in the single holding register and clears lsr_thre and lsr_temt in the next clock. A second write before the load replaces the first byte.
- R7: lsr_thre is 1 exactly when the holding stage is empty. lsr_temt is 1 only when the holding stage and the shift register are both empty.
- R8: With fifo_en = 1, a write is taken only while fewer than 16 bytes are queued, and queued bytes complete in write order.
- R9: Any change of fifo_en discards everything in the holding stage. The bytes never load, and lsr_thre returns to 1.
- R10: An internal pending flag is set when the holding stage becomes empty, or when irq_en rises while lsr_thre is 1. It is cleared by a taken write or by irq_ack. tx_irq is the pending flag masked by irq_en and follows the holding stage emptying by one clock.
- R11: The tick counter stops and returns to 0 when the holding stage and the shift register are both empty. tx_load and byte_done never pulse in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | 16 | Bit period divisor; 0 means 65536 |
| lcr | input | 4 | [1:0] word length−5, [2] second stop bit, [3] parity enable |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single holding register |
| wr_en | input | 1 | Host write strobe for the transmit data |
| wr_data | input | 8 | Byte written by the host |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| irq_ack | input | 1 | Clears the pending transmit-empty interrupt |
| bit_tick | output | 1 | One-clock pulse per bit period |
| tx_load | output | 1 | Pulse: a byte entered the shift register |
| byte_done | output | 1 | Pulse: a frame finished |
| done_data | output | 8 | Byte whose frame finished, valid with byte_done |
| lsr_thre | output | 1 | Holding stage empty |
| lsr_temt | output | 1 | Holding stage and shift register empty |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest situations to reach from the ports are a byte waiting in the holding stage while another frame is still shifting, and the queue boundary at sixteen entries. Both depend on where the writes land relative to the bit ticks. The bench therefore waits for bit_tick on the output and places a burst of writes right after it. The divisor is set large enough that the whole burst fits inside one bit period. Tick numbers for every load and completion are then computed from F and D and compared tick by tick.

// File: rtl/uart_txs_pkg.sv
// Shared line-control type and frame arithmetic for the transmit sequencer.
// Assumes the line-control nibble is {parity enable, second stop, word length-5}.
package uart_txs_pkg;

    typedef struct packed {
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_ctl_t;

    // Number of data bits carried by one frame (5..8).
    function automatic logic [3:0] data_bits(input line_ctl_t c);
        return 4'd5 + {2'b00, c.wlen};
    endfunction

    // Frame length in bit periods: start + data + stop(s) + parity.
    function automatic logic [3:0] frame_bits(input line_ctl_t c);
        return data_bits(c) + 4'd2 + {3'b000, c.two_stop} + {3'b000, c.par_en};
    endfunction

endpackage

// File: rtl/uart_txs_baud.sv
// Free-running bit-period tick generator.
// Emits a one-clock tick every divisor*2^OVS_W clocks; a zero divisor acts
// as 2^DIV_W. A divisor change takes effect at once; a counter already past
// the new limit ticks on the next clock.
module uart_txs_baud #(
    parameter int DIV_W = 16,
    parameter int OVS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int CNT_W = DIV_W + OVS_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count of the period; divisor-1 wraps zero to the full range.
    always_comb begin
        last = {divisor - DIV_W'(1), {OVS_W{1'b1}}};
        tick = (cnt >= last);
    end

    // Period counter, restarted on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/uart_txs_hold.sv
// Transmit holding stage: a DEPTH-entry queue, or a single overwritable
// holding register when fifo_en is low. Any change of fifo_en flushes it.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module uart_txs_hold #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       empty,
    output logic       wr_accept
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr, waddr;
    logic [CW-1:0] cnt;
    logic          fen_q, flush, pop_ok;

    // Mode change detection, accept and address selection.
    always_comb begin
        flush     = fifo_en ^ fen_q;
        pop_ok    = pop && (cnt != '0);
        wr_accept = wr_en && !flush && (!fifo_en || (cnt < CW'(DEPTH)));
        if (fifo_en)     waddr = wr_ptr;
        else if (pop_ok) waddr = rd_ptr + AW'(1);
        else             waddr = rd_ptr;
        empty   = (cnt == '0);
        rd_data = mem[rd_ptr];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_accept) mem[waddr] <= wr_data;
    end

    // Pointers, occupancy and mode history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            fen_q  <= 1'b0;
        end else begin
            fen_q <= fifo_en;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= '0;
                cnt    <= '0;
            end else begin
                if (pop_ok)    rd_ptr <= rd_ptr + AW'(1);
                if (wr_accept) wr_ptr <= waddr + AW'(1);
                if (!fifo_en)
                    cnt <= wr_accept ? CW'(1) : cnt - CW'(pop_ok);
                else
                    cnt <= cnt + CW'(wr_accept) - CW'(pop_ok);
            end
        end
    end
endmodule

// File: rtl/uart_txs_ctrl.sv
// Load/complete sequencer. Counts bit ticks while work exists and decides
// when the waiting byte enters the shift register and when its frame ends.
// Assumes the holding stage shows its head byte combinationally.
module uart_txs_ctrl
    import uart_txs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  line_ctl_t  ctl,
    input  logic       hold_empty,
    input  logic [7:0] hold_data,
    output logic       pop,
    output logic       shift_full,
    output logic       tx_load,
    output logic       byte_done,
    output logic [7:0] done_data
);
    logic [CNT_W-1:0] cnt, c1, load_at, done_at;
    logic [7:0]       shift_data;
    logic             sending, complete, load, idle;

    // Next count, load point and frame end for the present line settings.
    always_comb begin
        c1       = cnt + CNT_W'(1);
        done_at  = CNT_W'(frame_bits(ctl)) + CNT_W'(1);
        load_at  = sending ? CNT_W'(data_bits(ctl)) + CNT_W'(1) : CNT_W'(1);
        idle     = hold_empty && !shift_full;
        complete = tick && sending && shift_full && (c1 == done_at);
        load     = tick && !hold_empty && !shift_full && (c1 == load_at);
        pop      = load;
    end

    // Counter, shift-register occupancy and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            sending    <= 1'b0;
            shift_full <= 1'b0;
            shift_data <= '0;
            tx_load    <= 1'b0;
            byte_done  <= 1'b0;
            done_data  <= '0;
        end else begin
            tx_load   <= load;
            byte_done <= complete;
            if (complete) done_data <= shift_data;
            if (tick) begin
                if (idle) begin
                    cnt     <= '0;
                    sending <= 1'b0;
                end else if (complete) begin
                    cnt        <= '0;
                    shift_full <= 1'b0;
                    sending    <= !hold_empty;
                end else begin
                    cnt <= c1;
                    if (load) begin
                        shift_full <= 1'b1;
                        shift_data <= hold_data;
                        sending    <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_tx_sequencer.sv
// Top of the transmit holding/shift sequencer: tick generator, holding
// stage and load/complete control, plus line-status flags and the
// transmit-empty interrupt. Assumes the host decode supplies one-clock
// write and acknowledge strobes.
module uart_tx_sequencer
    import uart_txs_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS_W = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [3:0]       lcr,
    input  logic             fifo_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             bit_tick,
    output logic             tx_load,
    output logic             byte_done,
    output logic [7:0]       done_data,
    output logic             lsr_thre,
    output logic             lsr_temt,
    output logic             tx_irq
);
    localparam int SEQ_W = 4;

    line_ctl_t  ctl;
    logic       hold_empty, hold_pop, wr_accept, shift_full;
    logic [7:0] hold_data;
    logic       empty_q, irq_en_q, pending, set_evt;

    assign ctl = line_ctl_t'(lcr);

    uart_txs_baud #(.DIV_W(DIV_W), .OVS_W(OVS_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(bit_tick)
    );

    uart_txs_hold #(.DEPTH(DEPTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .wr_en(wr_en), .wr_data(wr_data), .pop(hold_pop),
        .rd_data(hold_data), .empty(hold_empty), .wr_accept(wr_accept)
    );

    uart_txs_ctrl #(.CNT_W(SEQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .ctl(ctl),
        .hold_empty(hold_empty), .hold_data(hold_data), .pop(hold_pop),
        .shift_full(shift_full), .tx_load(tx_load),
        .byte_done(byte_done), .done_data(done_data)
    );

    // Status flags and interrupt set conditions.
    always_comb begin
        lsr_thre = hold_empty;
        lsr_temt = hold_empty && !shift_full;
        set_evt  = (hold_empty && !empty_q) || (irq_en && !irq_en_q && hold_empty);
        tx_irq   = pending && irq_en;
    end

    // Transmit-empty pending flag: write clears first, then set, then ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            empty_q  <= 1'b1;
            irq_en_q <= 1'b0;
        end else begin
            empty_q  <= hold_empty;
            irq_en_q <= irq_en;
            if (wr_accept)    pending <= 1'b0;
            else if (set_evt) pending <= 1'b1;
            else if (irq_ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_sequencer_chk.sv
// Temporal checks on the sequencer ports, bound to every instance.
module uart_tx_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_en,
    input logic wr_en,
    input logic bit_tick,
    input logic tx_load,
    input logic byte_done,
    input logic lsr_thre,
    input logic lsr_temt,
    input logic tx_irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && rst_n) |-> (lsr_thre && lsr_temt && !tx_irq));
    // R3
    load_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(bit_tick));
    // R4
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(bit_tick));
    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fifo_en && $stable(fifo_en) && $past(rst_n)) |=> !lsr_thre);
    // R7
    temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_temt |-> lsr_thre);
    // R10
    irq_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> lsr_thre);
    // R11
    load_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_load, byte_done}));
endmodule

bind uart_tx_sequencer uart_tx_sequencer_chk u_chk (.*);

// File: tb/tb_uart_tx_sequencer.sv
`timescale 1ns/1ps
module tb_uart_tx_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [3:0]  lcr = 4'd0;
    logic        fifo_en = 1'b0, wr_en = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        bit_tick, tx_load, byte_done, lsr_thre, lsr_temt, tx_irq;
    logic [7:0]  done_data;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    uart_tx_sequencer dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .lcr(lcr),
        .fifo_en(fifo_en), .wr_en(wr_en), .wr_data(wr_data),
        .irq_en(irq_en), .irq_ack(irq_ack), .bit_tick(bit_tick),
        .tx_load(tx_load), .byte_done(byte_done), .done_data(done_data),
        .lsr_thre(lsr_thre), .lsr_temt(lsr_temt), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Return just after the clock edge that consumed the next bit tick.
    task automatic tick_step();
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int fbits(input int l);
        return 7 + (l & 3) + ((l >> 2) & 1) + ((l >> 3) & 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, nd, k1, k2, d1, d2, cnt;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 thre", lsr_thre, 1); chk("R1 temt", lsr_temt, 1);
        chk("R1 irq", tx_irq, 0);    chk("R1 pulses", tx_load | byte_done, 0);

        // R2 tick period sweep
        foreach (divisor[i]) if (i < 4) begin
            int d;
            d = (i == 3) ? 5 : i + 1;
            divisor = 16'(d);
            while (!bit_tick) @(negedge clk);
            while (bit_tick) @(negedge clk);
            n = 1;
            while (!bit_tick && n < 200) begin @(negedge clk); n++; end
            chk("R2 period", n, 16 * d);
        end
        divisor = 16'd0;
        cnt = 0;
        for (int i = 0; i < 5000; i++) begin @(negedge clk); cnt += int'(bit_tick); end
        chk("R2 zero divisor", cnt, 0);
        divisor = 16'd1;
        repeat (20) @(negedge clk);

        // R10 interrupt set, ack, write clear, mask
        irq_en = 1'b1; @(negedge clk);
        chk("R10 enable while empty", tx_irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R10 ack", tx_irq, 0);
        irq_en = 1'b0; @(negedge clk); irq_en = 1'b1; @(negedge clk);
        chk("R10 re-enable", tx_irq, 1);
        tick_step();
        wr(8'h55);
        chk("R10 write clears", tx_irq, 0);
        tick_step(); @(negedge clk);
        chk("R10 holding emptied", tx_irq, 1);
        irq_en = 1'b0; @(negedge clk);
        chk("R10 mask", tx_irq, 0);
        for (int k = 0; k < 20 && !lsr_temt; k++) tick_step();
        repeat (40) @(negedge clk);

        // R3 R4 R6 R7 R11: every line setting, idle gap before each write
        for (int l = 0; l < 16; l++) begin
            lcr = 4'(l);
            repeat (40) @(negedge clk);
            b = 8'(8'h3C + l * 29);
            wr(b);
            chk("R6 thre after write", lsr_thre, 0);
            chk("R6 temt after write", lsr_temt, 0);
            d1 = 0;
            for (int k = 1; k <= 20; k++) begin
                tick_step();
                if (tx_load) begin
                    chk("R3 load tick", k, 1);
                    chk("R7 thre on load", lsr_thre, 1);
                    chk("R7 temt on load", lsr_temt, 0);
                end
                if (byte_done) begin
                    d1 = k;
                    chk("R4 data", done_data, b);
                    chk("R7 temt on done", lsr_temt, 1);
                    break;
                end
            end
            chk("R4 frame end tick", d1, fbits(l) + 1);
        end

        // R5 R6 single holding register: overwrite, then wait behind a frame
        lcr = 4'd0;
        tick_step();
        wr(8'h11); wr(8'h22);
        chk("R6 thre", lsr_thre, 0);
        k1 = 0; k2 = 0; d1 = 0; d2 = 0;
        for (int k = 1; k <= 25; k++) begin
            tick_step();
            if (k == 2) wr(8'h33);
            if (tx_load && k > 1) k2 = k;
            if (byte_done && d1 == 0) begin
                d1 = k;
                chk("R6 overwrite data", done_data, 8'h22);
                chk("R7 temt with waiting byte", lsr_temt, 0);
            end else if (byte_done) begin
                d2 = k;
                chk("R5 second data", done_data, 8'h33);
            end
        end
        chk("R4 first done", d1, 8);
        chk("R5 second load", k2, 8 + 6);
        chk("R5 second done", d2, 16);

        // R5 R8 queue: 17 writes, 16 taken, spacing F+1
        fifo_en = 1'b1; divisor = 16'd2; lcr = 4'd3;
        repeat (3) @(negedge clk);
        tick_step();
        for (int i = 0; i < 17; i++) begin
            wr_data = 8'(8'h40 + i); wr_en = 1'b1; @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R7 thre with queue", lsr_thre, 0);
        nd = 0;
        for (int k = 1; k <= 200; k++) begin
            tick_step();
            if (tx_load && nd > 0) begin
                chk("R5 queued load tick", k, 11 * nd + 9);
                chk("R7 thre on queued load", lsr_thre, int'(nd == 15));
            end
            if (byte_done) begin
                chk("R8 order", done_data, 8'h40 + nd);
                chk("R5 completion tick", k, 11 * (nd + 1));
                nd++;
            end
        end
        chk("R8 sixteen taken", nd, 16);
        chk("R7 temt at end", lsr_temt, 1);

        // R9 flush on mode change, both directions
        tick_step();
        wr(8'hA1); wr(8'hA2); wr(8'hA3);
        chk("R9 queued", lsr_thre, 0);
        fifo_en = 1'b0; @(negedge clk); @(negedge clk);
        chk("R9 thre after flush", lsr_thre, 1);
        chk("R9 temt after flush", lsr_temt, 1);
        tick_step();
        wr(8'hB1);
        fifo_en = 1'b1; @(negedge clk); @(negedge clk);
        chk("R9 thre after enable", lsr_thre, 1);
        cnt = 0;
        for (int k = 0; k < 15; k++) begin tick_step(); cnt += int'(tx_load) + int'(byte_done); end
        chk("R9 nothing sent", cnt, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule